// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This block runs the refill of one cache line after a miss. When a miss is accepted, it asks memory for the line and names the word that memory should send first. The words then come back one per accepted beat and go straight into the data array. The word the processor missed on is also handed to the processor in the same cycle it arrives, so the processor restarts without waiting for the rest of the line.

A mode input selects the memory order. In wrapped mode the fetch starts at the missed word and continues upward, wrapping past the end of the line. In in-order mode the fetch starts at word zero, and the missed word is still forwarded as soon as it passes by. While the fill is running, a processor access to the line being filled is held only if its word has not been written yet. Accesses to other lines are never held. The line is marked valid once every word is in place. Only one fill runs at a time.

Top module: `lineFill`

## Requirements
- R1: In the cycle a miss is accepted (`missValid` high while `missReady` is high), `memReqValid` is high with `memReqIdx` equal to `missIdx`. `memReqOff` equals `missOff` when `wrapMode` is 1 and equals 0 when `wrapMode` is 0.
- R2: The k-th memory beat of a fill (k counted from 0) is written in the same cycle with `arrWrOff` = (start offset + k) mod WORDS. `arrWrData` equals `memRspData` and `arrWrIdx` equals the missed line index.
- R3: In each fill, `cpuRspValid` is high in exactly one cycle. That is the cycle in which the missed word is written, and `cpuRspData` carries that word.
- R4: With `wrapMode` 0, the missed word is forwarded on beat number `missOff`, counted from 0.
- R5: With `wrapMode` 1, the missed word is forwarded on the first beat of the fill.
- R6: `lineValidSet` is high for one cycle, in the cycle after the last of the WORDS beats, and `lineValidIdx` gives the filled line.
- R7: `missReady` is low from the cycle after acceptance until that last beat has been taken. A miss presented during this time issues no memory request.
- R8: `cpuRdStall` is high exactly when a fill is running, `cpuRdValid` is high, `cpuRdIdx` equals the line being filled, and the word at `cpuRdOff` was not written in an earlier cycle.
- R9: After reset, `missReady` is 1, and `memReqValid`, `arrWrEn`, `cpuRspValid`, `lineValidSet` and `cpuRdStall` are all 0.
- R10: A memory beat that arrives while no fill is running is ignored: nothing is written and nothing is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrapMode | input | 1 | 1 = wrapped fetch from the missed word, 0 = fetch from word 0 |
| missValid | input | 1 | Miss request |
| missIdx | input | IDX_W | Line index of the miss |
| missOff | input | OFF_W | Word offset of the miss |
| missReady | output | 1 | Unit is idle and accepts a miss |
| memReqValid | output | 1 | One-cycle fetch request to memory |
| memReqIdx | output | IDX_W | Line index to fetch |
| memReqOff | output | OFF_W | Word that memory sends first |
| memRspValid | input | 1 | Memory beat valid |
| memRspData | input | DATA_W | Memory beat data |
| cpuRspValid | output | 1 | Missed word forwarded to the processor |
| cpuRspData | output | DATA_W | Forwarded word |
| cpuRdValid | input | 1 | Processor access during the fill |
| cpuRdIdx | input | IDX_W | Line index of that access |
| cpuRdOff | input | OFF_W | Word offset of that access |
| cpuRdStall | output | 1 | Access must wait for its word |
| arrWrEn | output | 1 | Data array write strobe |
| arrWrIdx | output | IDX_W | Data array line index |
| arrWrOff | output | OFF_W | Data array word offset |
| arrWrData | output | DATA_W | Data array write data |
| lineValidSet | output | 1 | Set the valid bit of the filled line |
| lineValidIdx | output | IDX_W | Line whose valid bit is set |

## Verification
The bench uses the default sizes: 8-word lines, 32-bit words and a 6-bit line index. With 8 words, both edge offsets (0 and 7) can be tried, and the wrap from word 7 to word 0 happens inside a single fill. Gaps in the memory beats stretch a fill, so probes against the line being filled can land on words that have arrived and on words that have not. They also allow a miss to be presented while a fill is still running, and beats to arrive while the unit is idle.

// File: rtl/lineFillPkg.sv
package lineFillPkg;
  typedef enum logic {ST_IDLE, ST_FILL} lfStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic start;   // latch a new miss
    logic take;    // accept one memory beat
    logic busy;    // fill in progress
  } lfCtlT;
endpackage

// File: rtl/lineFillCtl.sv
module lineFillCtl
  import lineFillPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  missValid,
  input  logic  memRspValid,
  input  logic  lastWord,
  output lfCtlT ctl,
  output logic  missReady,
  output logic  validPulse
);
  lfStateT state, stateNext;

  assign missReady = (state == ST_IDLE);
  assign ctl.start = missValid && missReady;
  assign ctl.take  = (state == ST_FILL) && memRspValid;
  assign ctl.busy  = (state == ST_FILL);

  always_comb begin
    stateNext = state;
    if (ctl.start) stateNext = ST_FILL;
    else if (ctl.take && lastWord) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      validPulse <= 1'b0;
    end else begin
      state      <= stateNext;
      validPulse <= ctl.take && lastWord;
    end
  end
endmodule

// File: rtl/lineFillDp.sv
module lineFillDp
  import lineFillPkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfCtlT             ctl,
  input  logic              wrapMode,
  input  logic [IDX_W-1:0]  missIdx,
  input  logic [OFF_W-1:0]  missOff,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              cpuRdValid,
  input  logic [IDX_W-1:0]  cpuRdIdx,
  input  logic [OFF_W-1:0]  cpuRdOff,
  output logic              lastWord,
  output logic [OFF_W-1:0]  memReqOff,
  output logic [IDX_W-1:0]  fillIdx,
  output logic [OFF_W-1:0]  arrWrOff,
  output logic [DATA_W-1:0] arrWrData,
  output logic              cpuRspValid,
  output logic [DATA_W-1:0] cpuRspData,
  output logic              cpuRdStall
);
  logic [OFF_W-1:0] baseOff, needOff, beatCnt, curOff;
  logic [WORDS-1:0] arrived;

  // start word offered to memory
  assign memReqOff = wrapMode ? missOff : '0;
  // power-of-two line: the offset adder wraps by itself
  assign curOff    = baseOff + beatCnt;
  assign lastWord  = (beatCnt == OFF_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillIdx <= '0;
      baseOff <= '0;
      needOff <= '0;
      beatCnt <= '0;
    end else if (ctl.start) begin
      fillIdx <= missIdx;
      baseOff <= memReqOff;
      needOff <= missOff;
      beatCnt <= '0;
    end else if (ctl.take) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  // one arrival flag per word of the line
  for (genvar w = 0; w < WORDS; w++) begin : gArrived
    always_ff @(posedge clk) begin
      if (!rstN || ctl.start) arrived[w] <= 1'b0;
      else if (ctl.take && curOff == OFF_W'(w)) arrived[w] <= 1'b1;
    end
  end

  assign arrWrOff    = curOff;
  assign arrWrData   = memRspData;
  assign cpuRspValid = ctl.take && (curOff == needOff);
  assign cpuRspData  = memRspData;
  assign cpuRdStall  = ctl.busy && cpuRdValid && (cpuRdIdx == fillIdx) && !arrived[cpuRdOff];
endmodule

// File: rtl/lineFill.sv
module lineFill
  import lineFillPkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrapMode,
  input  logic              missValid,
  input  logic [IDX_W-1:0]  missIdx,
  input  logic [OFF_W-1:0]  missOff,
  output logic              missReady,
  output logic              memReqValid,
  output logic [IDX_W-1:0]  memReqIdx,
  output logic [OFF_W-1:0]  memReqOff,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              cpuRspValid,
  output logic [DATA_W-1:0] cpuRspData,
  input  logic              cpuRdValid,
  input  logic [IDX_W-1:0]  cpuRdIdx,
  input  logic [OFF_W-1:0]  cpuRdOff,
  output logic              cpuRdStall,
  output logic              arrWrEn,
  output logic [IDX_W-1:0]  arrWrIdx,
  output logic [OFF_W-1:0]  arrWrOff,
  output logic [DATA_W-1:0] arrWrData,
  output logic              lineValidSet,
  output logic [IDX_W-1:0]  lineValidIdx
);
  lfCtlT            ctl;
  logic             lastWord;
  logic [IDX_W-1:0] fillIdx;

  lineFillCtl u_ctl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .memRspValid(memRspValid),
    .lastWord(lastWord), .ctl(ctl), .missReady(missReady), .validPulse(lineValidSet)
  );

  lineFillDp #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrapMode(wrapMode), .missIdx(missIdx),
    .missOff(missOff), .memRspData(memRspData), .cpuRdValid(cpuRdValid),
    .cpuRdIdx(cpuRdIdx), .cpuRdOff(cpuRdOff), .lastWord(lastWord),
    .memReqOff(memReqOff), .fillIdx(fillIdx), .arrWrOff(arrWrOff),
    .arrWrData(arrWrData), .cpuRspValid(cpuRspValid), .cpuRspData(cpuRspData),
    .cpuRdStall(cpuRdStall)
  );

  assign memReqValid  = ctl.start;
  assign memReqIdx    = missIdx;
  assign arrWrEn      = ctl.take;
  assign arrWrIdx     = fillIdx;
  assign lineValidIdx = fillIdx;
endmodule

// File: rtl/lineFillChk.sv
module lineFillChk #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int OFF_W = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              missReady,
  input logic              memReqValid,
  input logic              memRspValid,
  input logic [DATA_W-1:0] memRspData,
  input logic              cpuRspValid,
  input logic [DATA_W-1:0] cpuRspData,
  input logic              cpuRdValid,
  input logic              cpuRdStall,
  input logic              arrWrEn,
  input logic [DATA_W-1:0] arrWrData,
  input logic              lineValidSet
);
  a_r1_req_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (missValid && missReady));
  a_r7_no_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    !missReady |-> !memReqValid);
  a_r2_write_is_beat: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (memRspValid && arrWrData == memRspData));
  a_r3_fwd_with_write: assert property (@(posedge clk) disable iff (!rstN)
    cpuRspValid |-> (arrWrEn && cpuRspData == arrWrData));
  a_r6_valid_after_write: assert property (@(posedge clk) disable iff (!rstN)
    lineValidSet |-> $past(arrWrEn));
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    lineValidSet |=> !lineValidSet);
  a_r8_stall_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdStall |-> (cpuRdValid && !missReady));
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    missReady |-> (!arrWrEn && !cpuRspValid));
endmodule

bind lineFill lineFillChk #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/lineFill_tb.sv
module lineFill_tb;
  localparam int WORDS = 8, DATA_W = 32, IDX_W = 6, OFF_W = 3;

  logic clk = 0, rstN = 0;
  logic wrapMode = 0, missValid = 0, memRspValid = 0, cpuRdValid = 0;
  logic [IDX_W-1:0] missIdx = '0, cpuRdIdx = '0;
  logic [OFF_W-1:0] missOff = '0, cpuRdOff = '0;
  logic [DATA_W-1:0] memRspData = '0;
  logic missReady, memReqValid, cpuRspValid, cpuRdStall, arrWrEn, lineValidSet;
  logic [IDX_W-1:0] memReqIdx, arrWrIdx, lineValidIdx;
  logic [OFF_W-1:0] memReqOff, arrWrOff;
  logic [DATA_W-1:0] cpuRspData, arrWrData;

  always #4 clk = ~clk;

  lineFill #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  bit mBusy = 0, mVp = 0;
  int mIdx = 0, mNeed = 0, mStart = 0, mCnt = 0, mVi = 0;
  bit mArr[WORDS];
  int beatNum = 0, fwdAt = -1, fwdCount = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every output against the model, then advance one clock
  task automatic cycle();
    bit eReq, eWr, eFwd, eStall;
    int eOff;
    #1;
    eReq = missValid && !mBusy;
    eWr  = mBusy && memRspValid;
    eOff = (mStart + mCnt) % WORDS;
    eFwd = eWr && (eOff == mNeed);
    eStall = mBusy && cpuRdValid && (int'(cpuRdIdx) == mIdx) && !mArr[cpuRdOff];
    chk(missReady == !mBusy, "R7", "missReady", missReady, !mBusy);
    chk(memReqValid == eReq, "R1", "memReqValid", memReqValid, eReq);
    if (eReq) begin
      chk(memReqIdx == missIdx, "R1", "memReqIdx", memReqIdx, missIdx);
      chk(int'(memReqOff) == (wrapMode ? int'(missOff) : 0), "R1", "memReqOff",
          memReqOff, wrapMode ? missOff : 0);
    end
    chk(arrWrEn == eWr, "R10", "arrWrEn", arrWrEn, eWr);
    if (eWr) begin
      chk(int'(arrWrOff) == eOff, "R2", "arrWrOff", arrWrOff, eOff);
      chk(int'(arrWrIdx) == mIdx, "R2", "arrWrIdx", arrWrIdx, mIdx);
      chk(arrWrData == memRspData, "R2", "arrWrData", arrWrData, memRspData);
    end
    chk(cpuRspValid == eFwd, "R3", "cpuRspValid", cpuRspValid, eFwd);
    if (eFwd) chk(cpuRspData == memRspData, "R3", "cpuRspData", cpuRspData, memRspData);
    if (cpuRspValid) begin fwdAt = beatNum; fwdCount++; end
    chk(lineValidSet == mVp, "R6", "lineValidSet", lineValidSet, mVp);
    if (mVp) chk(int'(lineValidIdx) == mVi, "R6", "lineValidIdx", lineValidIdx, mVi);
    chk(cpuRdStall == eStall, "R8", "cpuRdStall", cpuRdStall, eStall);
    @(posedge clk);
    mVp = 0;
    if (eReq) begin
      mBusy = 1; mIdx = missIdx; mNeed = missOff;
      mStart = wrapMode ? int'(missOff) : 0; mCnt = 0;
      foreach (mArr[i]) mArr[i] = 0;
      beatNum = 0; fwdAt = -1; fwdCount = 0;
    end else if (eWr) begin
      mArr[eOff] = 1; mCnt++; beatNum++;
      if (mCnt == WORDS) begin mBusy = 0; mVp = 1; mVi = mIdx; end
    end
    @(negedge clk);
  endtask

  // one complete fill; gapEvery>0 inserts idle beats, probes hit the fill line
  task automatic fill(bit wm, int idx, int off, int gapEvery, bit retryMiss);
    int taken = 0, cyc = 0;
    wrapMode = wm; missValid = 1; missIdx = IDX_W'(idx); missOff = OFF_W'(off);
    cycle();
    missValid = retryMiss; missIdx = IDX_W'(idx + 1);
    while (taken < WORDS) begin
      memRspValid = !(gapEvery > 0 && (cyc % gapEvery) == 1);
      memRspData = 32'hC0DE_0000 + (idx << 8) + cyc;
      cpuRdValid = 1;
      cpuRdIdx = (cyc % 5 == 4) ? IDX_W'(idx + 2) : IDX_W'(idx);
      cpuRdOff = OFF_W'(off + cyc * 3);
      if (memRspValid) taken++;
      cycle();
      cyc++;
    end
    memRspValid = 0; cpuRdValid = 0; missValid = 0;
    cycle();  // cycle of lineValidSet
    chk(fwdCount == 1, "R3", "forwards per fill", fwdCount, 1);
    if (wm) chk(fwdAt == 0, "R5", "forward beat", fwdAt, 0);
    else    chk(fwdAt == off, "R4", "forward beat", fwdAt, off);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(missReady == 1, "R9", "missReady in reset", missReady, 1);
    chk(!memReqValid && !arrWrEn && !cpuRspValid && !lineValidSet && !cpuRdStall,
        "R9", "outputs quiet in reset", 0, 0);
    @(negedge clk); rstN = 1;
    // beats while idle are ignored (R10)
    memRspValid = 1; memRspData = 32'hDEAD_BEEF; cycle(); cycle();
    memRspValid = 0; cycle();
    fill(1, 5, 5, 0, 0);   // R5 wrapped, wraps past word 7
    fill(0, 9, 6, 3, 0);   // R4 in-order with gaps
    fill(1, 12, 7, 2, 1);  // R7 miss retried during fill
    fill(0, 3, 0, 0, 0);   // R4 boundary offset 0
    fill(0, 33, 7, 4, 0);  // R4 boundary offset 7
    fill(1, 63, 0, 3, 1);  // R5 offset 0, no wrap
    memRspValid = 1; cycle(); memRspValid = 0; cycle();  // R10 after fills
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule